// File: doc/BRIEF.md
# Multiplexed-Bus SRAM Memory Target

This block is a memory slave on an asynchronous backplane bus whose address and data share one set of lines. It is modelled inside one clock domain, and the bus strobes are sampled as active-high levels. When the transfer-start strobe rises, the block captures the address and decides whether the transfer is its own. It then drives chip enables and a write strobe to byte-wide external SRAMs that are fitted in pairs. On a read it returns the addressed word. On a write it stores a full word or a single byte. In both cases it raises its reply only after a fixed number of settling clocks.

Two setup inputs fix the addressing width and the number of installed chip pairs. The block never claims the I/O page, which is the top 8 KB of the active address space. It also refuses any transfer for which the external I/O-page qualifier was raised at address time, and any transfer that begins while an earlier reply is still held.

Top module: `mux_bus_sram_target`

## Requirements
- R1: The address is taken from `bus_ad_in` on the clock edge where `bus_start` is first seen high. Later changes on `bus_ad_in` during the same transfer leave `mem_addr` unchanged.
- R2: `mem_ce` is all zero whenever `bus_start` is low. The selection is forgotten once `bus_start` is released.
- R3: `bus_ack` rises exactly SETTLE clock edges after a read or write strobe is first sampled on a selected transfer. It falls in the same cycle that both strobes go low.
- R4: There is no response when every bit of the latched address from bit 13 up to the top bit of the active width is 1 (the I/O page).
- R5: `cfg_mode` sets the active width: 0 is 16-bit, 1 is 18-bit, and 2 or 3 is 22-bit. Address bits above the active width are ignored. `mem_addr` carries latched bits 19:1, with the ignored bits read as zero.
- R6: In 22-bit mode, address bits 21:20 pick pair p, and `cfg_pairs` holds the number of installed pairs minus one. A pair above `cfg_pairs` gets no response. In the narrower modes only pair 0 is used and `cfg_pairs` is ignored. Chip 2p holds the low byte of pair p and chip 2p+1 holds the high byte.
- R7: On a selected read (`bus_rd` high), both chips of the pair are enabled, `mem_we` is low, `bus_data_oe` is high, and `bus_data_out` equals `mem_rdata`.
- R8: On a selected word write (`bus_wr` high), both chips of the pair are enabled, `mem_we` is high, and `mem_wdata` equals `bus_ad_in[15:0]`.
- R9: If `bus_byte` was high at address time, a write enables only one chip. Latched address bit 0 picks it: 0 selects chip 2p and 1 selects chip 2p+1.
- R10: If `bus_iopage` is high at address time, the transfer gets no response.
- R11: If `bus_start` rises while `bus_ack` is still high, that transfer gets no response for its whole duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mode | input | 2 | Addressing width select |
| cfg_pairs | input | 2 | Installed chip pairs minus one (22-bit mode) |
| bus_ad_in | input | 22 | Shared address/data lines |
| bus_start | input | 1 | Transfer-start strobe |
| bus_rd | input | 1 | Read data strobe |
| bus_wr | input | 1 | Write data strobe |
| bus_byte | input | 1 | Byte-write flag, sampled with the address |
| bus_iopage | input | 1 | I/O-page qualifier, sampled with the address |
| bus_data_out | output | 16 | Read data toward the bus |
| bus_data_oe | output | 1 | Read data valid/drive enable |
| bus_ack | output | 1 | Reply strobe |
| mem_addr | output | 19 | Word address to the SRAMs |
| mem_ce | output | 8 | Chip enables, two per pair |
| mem_we | output | 1 | Shared SRAM write strobe |
| mem_wdata | output | 16 | Write data to the SRAMs |
| mem_rdata | input | 16 | Read data from the selected pair |

## Verification
The assertions assume that the master behaves as a bus master should. It raises `bus_start` with a stable address before it raises a data strobe, it never raises both strobes at once, and it changes `cfg_mode` and `cfg_pairs` only while the bus is idle. The bench drives every input on the falling clock edge in that order and changes the setup inputs only between transfers. It breaks the ordering on purpose in only two places: it releases `bus_start` while a strobe is still high, and it restarts a transfer while a reply is still held. Both are bus states that the block has to tolerate.

// File: rtl/mux_bus_sram_target.sv
module mux_bus_sram_target #(
  parameter int SETTLE = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cfg_mode,
  input  logic [1:0]  cfg_pairs,
  input  logic [21:0] bus_ad_in,
  input  logic        bus_start,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic        bus_byte,
  input  logic        bus_iopage,
  output logic [15:0] bus_data_out,
  output logic        bus_data_oe,
  output logic        bus_ack,
  output logic [18:0] mem_addr,
  output logic [7:0]  mem_ce,
  output logic        mem_we,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata
);
  localparam int NPAIR = 4;
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

  logic          start_q, sel_q, byte_q, ack_q;
  logic [21:0]   adr_q, mask;
  logic [CW-1:0] cnt;
  logic          io_hit, in_range;

  wire start_rise = bus_start & ~start_q;
  wire strobe     = bus_rd | bus_wr;
  wire act        = sel_q & bus_start & strobe;

  always_comb begin
    case (cfg_mode)
      2'd0: begin mask = 22'h00FFFF; io_hit = &bus_ad_in[15:13]; in_range = 1'b1; end
      2'd1: begin mask = 22'h03FFFF; io_hit = &bus_ad_in[17:13]; in_range = 1'b1; end
      default: begin
        mask = 22'h3FFFFF;
        io_hit = &bus_ad_in[21:13];
        in_range = bus_ad_in[21:20] <= cfg_pairs;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      sel_q   <= 1'b0;
      byte_q  <= 1'b0;
      adr_q   <= '0;
    end else begin
      start_q <= bus_start;
      if (!bus_start) sel_q <= 1'b0;
      else if (start_rise) begin
        sel_q  <= in_range & ~io_hit & ~bus_iopage & ~ack_q;
        adr_q  <= bus_ad_in & mask;
        byte_q <= bus_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ack_q <= 1'b0;
    end else begin
      cnt   <= (!act || ack_q) ? '0 : cnt + 1'b1;
      ack_q <= strobe & (ack_q | (act & (cnt == LAST)));
    end
  end

  wire [1:0] lanes = (bus_wr & byte_q) ? (adr_q[0] ? 2'b10 : 2'b01) : 2'b11;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign mem_ce[2*p+1:2*p] = (act && adr_q[21:20] == 2'(p)) ? lanes : 2'b00;
  end

  assign mem_addr     = adr_q[19:1];
  assign mem_we       = act & bus_wr;
  assign mem_wdata    = bus_ad_in[15:0];
  assign bus_data_oe  = act & bus_rd & ~bus_wr;
  assign bus_data_out = bus_data_oe ? mem_rdata : 16'h0000;
  assign bus_ack      = ack_q & strobe;

  assert_addr_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && bus_start && $past(sel_q && bus_start)) |-> $stable(mem_addr));

  assert_reply_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack) |-> $past(act));

  assert_one_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mem_ce) <= 2);

  assert_single_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && byte_q) |-> $countones(mem_ce) <= 1);

  assert_iopage_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_start) && bus_iopage) |=> mem_ce == 8'h00);
endmodule

// File: tb/tb_mux_bus_sram_target.sv
module tb_mux_bus_sram_target;
  localparam int SETTLE = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'd0, cfg_pairs = 2'd3;
  logic [21:0] bus_ad_in = '0;
  logic bus_start = 0, bus_rd = 0, bus_wr = 0, bus_byte = 0, bus_iopage = 0;
  logic [15:0] bus_data_out, mem_wdata, mem_rdata;
  logic bus_data_oe, bus_ack, mem_we;
  logic [18:0] mem_addr;
  logic [7:0] mem_ce;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;
  assign mem_rdata = mem_addr[15:0] ^ 16'h5A3C;

  mux_bus_sram_target #(.SETTLE(SETTLE)) dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic xfer(input logic [21:0] a, input logic wr, input logic byt, input logic io,
                      input logic [15:0] wd, output logic [7:0] ce, output logic [18:0] ma,
                      output logic we, output logic oe, output logic [15:0] dq,
                      output logic [15:0] wq, output int lat, output logic ack_rel);
    @(negedge clk);
    bus_ad_in = a; bus_byte = byt; bus_iopage = io; bus_start = 1;
    @(negedge clk);
    bus_ad_in = {6'h3F, wr ? wd : 16'hFFFF}; bus_byte = 0; bus_iopage = 0;
    if (wr) bus_wr = 1; else bus_rd = 1;
    #1;
    ce = mem_ce; ma = mem_addr; we = mem_we; oe = bus_data_oe; dq = bus_data_out; wq = mem_wdata;
    lat = -1;
    for (int i = 1; i <= 12 && lat < 0; i++) begin
      @(negedge clk);
      if (bus_ack) lat = i;
    end
    bus_rd = 0; bus_wr = 0;
    #1 ack_rel = bus_ack;
    @(negedge clk);
    bus_start = 0; bus_ad_in = '0;
  endtask

  task automatic run_case(input string tag, input logic [1:0] mode, input logic [1:0] pairs,
                          input logic [21:0] a, input logic wr, input logic byt,
                          input logic io, input logic [15:0] wd);
    logic [7:0] ce, ece; logic [18:0] ma; logic we, oe, rel; logic [15:0] dq, wq;
    int lat, w, p; logic [21:0] am; logic [1:0] ln;
    cfg_mode = mode; cfg_pairs = pairs;
    w  = (mode == 0) ? 16 : (mode == 1) ? 18 : 22;
    am = a & 22'((32'h1 << w) - 1);
    p  = (w == 22) ? int'(am[21:20]) : 0;
    if (io || ((am >> 13) == 22'((32'h1 << (w - 13)) - 1)) || (w == 22 && am[21:20] > pairs)) p = -1;
    xfer(a, wr, byt, io, wd, ce, ma, we, oe, dq, wq, lat, rel);
    if (p < 0) begin
      chk(ce == 8'h00, tag, ce, 0);
      chk(lat == -1, tag, lat, -1);
    end else begin
      ln  = (wr && byt) ? (am[0] ? 2'b10 : 2'b01) : 2'b11;
      ece = 8'(ln) << (2 * p);
      chk(ce == ece, tag, ce, ece);
      chk(ma == am[19:1], {tag, " R1 addr"}, ma, am[19:1]);
      chk(lat == SETTLE, {tag, " R3 latency"}, lat, SETTLE);
      chk(rel == 1'b0, {tag, " R3 release"}, rel, 0);
      if (wr) begin
        chk(we == 1'b1 && oe == 1'b0, {tag, " R8 strobe"}, {we, oe}, 2'b10);
        chk(wq == wd, {tag, " R8 data"}, wq, wd);
      end else begin
        chk(oe == 1'b1 && we == 1'b0, {tag, " R7 enable"}, {we, oe}, 2'b01);
        chk(dq == (am[16:1] ^ 16'h5A3C), {tag, " R7 data"}, dq, am[16:1] ^ 16'h5A3C);
      end
    end
  endtask

  task automatic t_reset;
    chk(bus_ack == 0 && mem_ce == 0 && bus_data_oe == 0 && mem_we == 0, "R2 reset",
        {bus_ack, mem_ce, bus_data_oe, mem_we}, 0);
  endtask

  task automatic t_reads;
    run_case("R7 read16", 2'd0, 2'd0, 22'h001234, 0, 0, 0, 0);
    run_case("R5 read18", 2'd1, 2'd0, 22'h02A468, 0, 0, 0, 0);
    run_case("R5 upper bits ignored", 2'd0, 2'd0, 22'h3F0010, 0, 0, 0, 0);
  endtask

  task automatic t_writes;
    run_case("R8 word write pair1", 2'd2, 2'd3, 22'h123456, 1, 0, 0, 16'hBEEF);
    run_case("R9 byte even", 2'd2, 2'd3, 22'h2ABC10, 1, 1, 0, 16'h0077);
    run_case("R9 byte odd", 2'd2, 2'd3, 22'h3ABC11, 1, 1, 0, 16'h8800);
  endtask

  task automatic t_iopage;
    run_case("R4 io16", 2'd0, 2'd0, 22'h00E000, 0, 0, 0, 0);
    run_case("R4 io18", 2'd1, 2'd0, 22'h03E002, 0, 0, 0, 0);
    run_case("R4 seg6 in 18-bit", 2'd1, 2'd0, 22'h00E000, 0, 0, 0, 0);
    run_case("R4 io22", 2'd2, 2'd3, 22'h3FFFFE, 1, 0, 0, 16'h1111);
    run_case("R10 iopage input", 2'd0, 2'd0, 22'h000400, 0, 0, 1, 0);
  endtask

  task automatic t_pairs;
    run_case("R6 pair beyond installed", 2'd2, 2'd1, 22'h200000, 0, 0, 0, 0);
    run_case("R6 last installed pair", 2'd2, 2'd1, 22'h1FFF00, 0, 0, 0, 0);
    run_case("R6 cfg_pairs ignored in 18-bit", 2'd1, 2'd0, 22'h010000, 0, 0, 0, 0);
  endtask

  task automatic t_release;
    cfg_mode = 2'd0;
    @(negedge clk); bus_ad_in = 22'h000100; bus_start = 1;
    @(negedge clk); bus_rd = 1;
    @(negedge clk); bus_start = 0;
    #1 chk(mem_ce == 0 && bus_data_oe == 0, "R2 start released", {mem_ce, bus_data_oe}, 0);
    @(negedge clk); bus_rd = 0;
    #1 chk(mem_ce == 0, "R2 idle", mem_ce, 0);
  endtask

  task automatic t_busy;
    cfg_mode = 2'd0;
    @(negedge clk); bus_ad_in = 22'h000200; bus_start = 1;
    @(negedge clk); bus_rd = 1;
    repeat (SETTLE) @(negedge clk);
    chk(bus_ack == 1, "R11 reply held", bus_ack, 1);
    bus_start = 0;
    @(negedge clk); bus_start = 1; bus_ad_in = 22'h000300;
    @(negedge clk);
    #1 chk(mem_ce == 0, "R11 restart during reply", mem_ce, 0);
    bus_rd = 0;
    #1 chk(bus_ack == 0, "R3 release on strobe drop", bus_ack, 0);
    @(negedge clk); bus_rd = 1;
    repeat (SETTLE + 2) @(negedge clk);
    chk(bus_ack == 0 && mem_ce == 0 && bus_data_oe == 0, "R11 cycle stays ignored",
        {bus_ack, mem_ce, bus_data_oe}, 0);
    bus_rd = 0;
    @(negedge clk); bus_start = 0;
    run_case("R11 next cycle served", 2'd0, 2'd0, 22'h000300, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reads();
    t_writes();
    t_iopage();
    t_pairs();
    t_release();
    t_busy();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule